// File: doc/BRIEF.md
# Event Match Timer

A free-running up-counter paired with a bank of comparison values and a bank of programmable events. Each event is armed by software, watches one chosen comparison value, and fires when the counter reaches that value. The events fire on a prescaled time base. The result appears as a registered vector of event pulses, one bit per event, which downstream logic uses to set or clear outputs or to form PWM waveforms.

Any event may be marked as a period terminator in a mask. When a marked event fires, the counter returns to zero instead of advancing. Writing N-1 into the comparison value watched by such an event therefore gives a period of N counts. Each comparison value has a shadow copy. At every period boundary all comparison values are refreshed from their shadows, so a new duty or period takes effect cleanly at the start of the next period. This refresh can be switched off. A halt bit freezes the time base. All settings are reached through a small word-addressed register port with single-cycle writes and combinational reads.

Top module: `emt_core`

## Requirements
- R1: After reset the counter is 0, the event vector is 0, every register reads 0 except the control word, which reads 0x0000_0004 (halted).
- R2: A register read returns the implemented fields of the last value written, with other bits 0. The implemented fields are: setup word at 0x000, bit 0 (unified, stored only) and bit 7 (refresh disable). Control word at 0x004, bit 2 (halt), bit 4 (direction, stored only) and bits 12:5 (prescale divider). Limit mask at 0x008, bits 15:0. Comparison value n at 0x100+4n, all 32 bits. Shadow n at 0x200+4n, all 32 bits. Event n arm word at 0x300+8n, bit 0. Event n setup word at 0x304+8n, bits 3:0 (comparison select) and bits 13:12 (trigger mode).
- R3: While not halted, the counter advances once every D+1 clocks, where D is the prescale divider.
- R4: An event fires when all three of these hold: its arm bit is 1, its trigger mode is 1, and the counter equals the comparison value it selects. The event's bit in the output vector reflects that firing for exactly one prescaled count, starting on the clock edge of that count.
- R5: An event whose trigger mode is not 1, or whose arm bit is 0, never produces a pulse.
- R6: When a firing event is set in the limit mask, the next count is 0 instead of counter+1. A comparison value of N-1 gives a period of N counts.
- R7: At a limit count, every comparison value is loaded from its shadow, unless refresh disable (bit 7 of the setup word) is 1.
- R8: A bus write to a comparison value in the same clock as a shadow refresh wins.
- R9: The counter reads at 0x040, and writes there are ignored.
- R10: While halted, the counter and the prescaler hold, and the event vector is 0 from the next clock on.
- R11: Setting the direction bit does not change counting: the counter still counts upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per clock |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| evt_o | output | N_EVT (16) | Registered event pulse vector |

## Verification
The bench runs a step model of the counter, prescaler, event and refresh rules beside the core, and compares the counter and the event vector in every cycle. It targets four corner cases:
- **Write racing the boundary refresh.** A core that lets the refresh win would read back the shadow value instead of the written one.
- **Refresh-disable bit.** A core that ignores it would adopt the new period from the shadow.
- **Unarmed or wrongly moded events.** A core that checks only the comparison would pulse these bits.
- **Prescale divider above zero.** An off-by-one divider would drift from the model within a few periods.

Random phases mix comparison and shadow rewrites during counting, so a match value can jump behind the counter. This tests that the wrap comes only from a limit event.

// File: rtl/emt_pkg.sv
package emt_pkg;
   // register offsets (byte addresses)
   localparam logic [11:0] OFS_SETUP = 12'h000;
   localparam logic [11:0] OFS_CTRL  = 12'h004;
   localparam logic [11:0] OFS_LIMIT = 12'h008;
   localparam logic [11:0] OFS_COUNT = 12'h040;
   // 256-byte pages holding the banked registers
   localparam logic [3:0] PAGE_CMP    = 4'h1;
   localparam logic [3:0] PAGE_SHADOW = 4'h2;
   localparam logic [3:0] PAGE_EVENT  = 4'h3;
   // field positions
   localparam int SETUP_UNIFIED_BIT = 0;
   localparam int SETUP_NOREFR_BIT  = 7;
   localparam int CTRL_HALT_BIT     = 2;
   localparam int CTRL_DIR_BIT      = 4;
   localparam int CTRL_DIV_LSB      = 5;
   localparam int EVT_MODE_LSB      = 12;
   // trigger mode of an event; only the pure comparison mode is built
   typedef enum logic [1:0] {
      TRIG_ANY   = 2'd0,
      TRIG_MATCH = 2'd1,
      TRIG_PIN   = 2'd2,
      TRIG_BOTH  = 2'd3
   } trig_mode_e;
endpackage

// File: rtl/emt_prescaler.sv
module emt_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);
   logic [PRE_W-1:0] pre_q;

   // >= keeps the divider safe when it is lowered below the running count
   assign tick = !halt && (pre_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pre_q <= '0;
      else if (halt || tick) pre_q <= '0;
      else                   pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/emt_counter.sv
module emt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wrap,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/emt_event_slice.sv
module emt_event_slice
   import emt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int N_MATCH = 16,
   parameter int SEL_W   = 4
) (
   input  logic [CNT_W-1:0]              cnt,
   input  logic [N_MATCH-1:0][CNT_W-1:0] match_vals,
   input  logic [SEL_W-1:0]              sel,
   input  logic [1:0]                    mode,
   input  logic                          arm,
   output logic                          fire
);
   logic [CNT_W-1:0] picked;
   logic             sel_ok;

   generate
      if ((1 << SEL_W) == N_MATCH) begin : g_full_sel
         assign picked = match_vals[sel];
         assign sel_ok = 1'b1;
      end else begin : g_part_sel
         always_comb begin
            picked = '0;
            sel_ok = 1'b0;
            for (int n = 0; n < N_MATCH; n++) begin
               if (sel == SEL_W'(n)) begin
                  picked = match_vals[n];
                  sel_ok = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign fire = arm && (mode == 2'(TRIG_MATCH)) && sel_ok && (cnt == picked);
endmodule

// File: rtl/emt_core.sv
module emt_core
   import emt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int N_EVT   = 16,
   parameter int N_MATCH = 16,
   parameter int PRE_W   = 8,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_EVT-1:0]  evt_o
);
   localparam int SEL_W = (N_MATCH > 1) ? $clog2(N_MATCH) : 1;
   localparam int HI_W  = ADDR_W - 8;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("emt_core: CNT_W must lie in 2..DATA_W");
      end
      if (N_EVT < 1 || N_EVT > 32) begin : g_bad_evt
         $error("emt_core: N_EVT must lie in 1..32");
      end
      if (N_MATCH < 1 || N_MATCH > 64) begin : g_bad_match
         $error("emt_core: N_MATCH must lie in 1..64");
      end
      if (PRE_W < 1 || PRE_W + CTRL_DIV_LSB > DATA_W) begin : g_bad_pre
         $error("emt_core: PRE_W does not fit the control word");
      end
      if (SEL_W > EVT_MODE_LSB) begin : g_bad_sel
         $error("emt_core: select field overlaps the trigger mode");
      end
      if (ADDR_W < 12 || N_EVT > DATA_W) begin : g_bad_bus
         $error("emt_core: bus too narrow for the register map");
      end
   endgenerate

   // ---------------- register state ----------------
   logic                          setup_unified, setup_norefr;
   logic                          ctl_halt, ctl_dir;
   logic [PRE_W-1:0]              ctl_div;
   logic [N_EVT-1:0]              limit_q;
   logic [N_MATCH-1:0][CNT_W-1:0] match_q, shadow_q;
   logic [N_EVT-1:0][SEL_W-1:0]   ev_sel;
   logic [N_EVT-1:0][1:0]         ev_mode;
   logic [N_EVT-1:0]              ev_arm;

   logic [CNT_W-1:0] cnt_q;
   logic             tick;
   logic [N_EVT-1:0] fire_vec;
   logic             limit_hit, refresh;

   // ---------------- address decode ----------------
   logic [HI_W-1:0] page;
   logic [5:0]      word_idx;
   logic [4:0]      evt_idx;
   logic            in_cmp, in_shadow, in_event;
   logic            wr_setup, wr_ctrl, wr_limit;

   assign page      = bus_addr[ADDR_W-1:8];
   assign word_idx  = bus_addr[7:2];
   assign evt_idx   = bus_addr[7:3];
   assign in_cmp    = (page == HI_W'(PAGE_CMP))    && (bus_addr[1:0] == 2'b00);
   assign in_shadow = (page == HI_W'(PAGE_SHADOW)) && (bus_addr[1:0] == 2'b00);
   assign in_event  = (page == HI_W'(PAGE_EVENT))  && (bus_addr[1:0] == 2'b00);
   assign wr_setup  = bus_wr && (bus_addr == ADDR_W'(OFS_SETUP));
   assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_limit  = bus_wr && (bus_addr == ADDR_W'(OFS_LIMIT));

   // ---------------- global registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_unified <= 1'b0;
         setup_norefr  <= 1'b0;
         ctl_halt      <= 1'b1;
         ctl_dir       <= 1'b0;
         ctl_div       <= '0;
         limit_q       <= '0;
      end else begin
         if (wr_setup) begin
            setup_unified <= bus_wdata[SETUP_UNIFIED_BIT];
            setup_norefr  <= bus_wdata[SETUP_NOREFR_BIT];
         end
         if (wr_ctrl) begin
            ctl_halt <= bus_wdata[CTRL_HALT_BIT];
            ctl_dir  <= bus_wdata[CTRL_DIR_BIT];
            ctl_div  <= bus_wdata[CTRL_DIV_LSB +: PRE_W];
         end
         if (wr_limit) limit_q <= bus_wdata[N_EVT-1:0];
      end
   end

   // ---------------- time base ----------------
   emt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .halt  (ctl_halt),
      .div   (ctl_div),
      .tick  (tick)
   );

   assign limit_hit = |(fire_vec & limit_q);
   assign refresh   = tick && limit_hit && !setup_norefr;

   emt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .wrap  (limit_hit),
      .cnt   (cnt_q)
   );

   // ---------------- comparison values and shadows ----------------
   for (genvar n = 0; n < N_MATCH; n++) begin : g_cmp
      logic wr_cmp_n, wr_shd_n;
      assign wr_cmp_n = bus_wr && in_cmp    && (word_idx == 6'(n));
      assign wr_shd_n = bus_wr && in_shadow && (word_idx == 6'(n));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            match_q[n]  <= '0;
            shadow_q[n] <= '0;
         end else begin
            if (wr_shd_n) shadow_q[n] <= bus_wdata[CNT_W-1:0];
            // a bus write beats the boundary refresh
            if (wr_cmp_n)     match_q[n] <= bus_wdata[CNT_W-1:0];
            else if (refresh) match_q[n] <= shadow_q[n];
         end
      end
   end

   // ---------------- events ----------------
   for (genvar e = 0; e < N_EVT; e++) begin : g_evt
      logic wr_arm_e, wr_set_e;
      assign wr_arm_e = bus_wr && in_event && (evt_idx == 5'(e)) && !bus_addr[2];
      assign wr_set_e = bus_wr && in_event && (evt_idx == 5'(e)) &&  bus_addr[2];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ev_arm[e]  <= 1'b0;
            ev_sel[e]  <= '0;
            ev_mode[e] <= 2'(TRIG_ANY);
         end else begin
            if (wr_arm_e) ev_arm[e] <= bus_wdata[0];
            if (wr_set_e) begin
               ev_sel[e]  <= bus_wdata[SEL_W-1:0];
               ev_mode[e] <= bus_wdata[EVT_MODE_LSB +: 2];
            end
         end
      end

      emt_event_slice #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .SEL_W(SEL_W)) u_slice (
         .cnt        (cnt_q),
         .match_vals (match_q),
         .sel        (ev_sel[e]),
         .mode       (ev_mode[e]),
         .arm        (ev_arm[e]),
         .fire       (fire_vec[e])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        evt_o <= '0;
      else if (ctl_halt) evt_o <= '0;
      else if (tick)     evt_o <= fire_vec;
   end

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_SETUP)) begin
         bus_rdata[SETUP_UNIFIED_BIT] = setup_unified;
         bus_rdata[SETUP_NOREFR_BIT]  = setup_norefr;
      end else if (bus_addr == ADDR_W'(OFS_CTRL)) begin
         bus_rdata[CTRL_HALT_BIT]            = ctl_halt;
         bus_rdata[CTRL_DIR_BIT]             = ctl_dir;
         bus_rdata[CTRL_DIV_LSB +: PRE_W]    = ctl_div;
      end else if (bus_addr == ADDR_W'(OFS_LIMIT)) begin
         bus_rdata[N_EVT-1:0] = limit_q;
      end else if (bus_addr == ADDR_W'(OFS_COUNT)) begin
         bus_rdata[CNT_W-1:0] = cnt_q;
      end else if (in_cmp || in_shadow) begin
         for (int n = 0; n < N_MATCH; n++) begin
            if (word_idx == 6'(n))
               bus_rdata[CNT_W-1:0] = in_cmp ? match_q[n] : shadow_q[n];
         end
      end else if (in_event) begin
         for (int e = 0; e < N_EVT; e++) begin
            if (evt_idx == 5'(e)) begin
               if (bus_addr[2]) begin
                  bus_rdata[SEL_W-1:0]            = ev_sel[e];
                  bus_rdata[EVT_MODE_LSB +: 2]    = ev_mode[e];
               end else begin
                  bus_rdata[0] = ev_arm[e];
               end
            end
         end
      end
   end
endmodule

// File: rtl/emt_core_chk.sv
module emt_core_chk #(
   parameter int CNT_W = 32,
   parameter int N_EVT = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             halt,
   input logic             hit,
   input logic [N_EVT-1:0] fire,
   input logic [CNT_W-1:0] cnt,
   input logic [N_EVT-1:0] evt
);
   // R3: no prescaled count, no movement
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   // R3: an ordinary count advances by one
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hit) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R6: a limit event sends the counter to zero
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && hit) |=> (cnt == '0));

   // R4: the pulse vector carries what fired on the count just taken
   a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (evt == $past(fire)));

   // R10: halting silences the pulses and stops the time base
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (evt == '0));

   a_r10_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !tick);
endmodule

bind emt_core emt_core_chk #(.CNT_W(CNT_W), .N_EVT(N_EVT)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .tick  (tick),
   .halt  (ctl_halt),
   .hit   (limit_hit),
   .fire  (fire_vec),
   .cnt   (cnt_q),
   .evt   (evt_o)
);

// File: tb/emt_core_test.sv
module emt_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = 12'h040;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] evt_o;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    chk_en = 1'b0;
   bit    done = 1'b0;
   string tag = "R1";

   always #4 clk = ~clk;   // 125 MHz

   emt_core uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_o     (evt_o)
   );

   // ---------------- step model built from the requirements ----------------
   logic        m_unified, m_norefr, m_halt, m_dir;
   logic [7:0]  m_div, m_pre;
   logic [15:0] m_limit, m_evt, m_fire;
   logic [31:0] m_cnt;
   logic [31:0] m_match [16];
   logic [31:0] m_shadow [16];
   logic [3:0]  m_sel [16];
   logic [1:0]  m_mode [16];
   logic        m_arm [16];
   logic        m_tick, m_hit;

   function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
      if (a == 12'h000) begin m_unified = d[0]; m_norefr = d[7]; end
      else if (a == 12'h004) begin m_halt = d[2]; m_dir = d[4]; m_div = d[12:5]; end
      else if (a == 12'h008) m_limit = d[15:0];
      else if (a[11:8] == 4'h1 && a[1:0] == 2'b00 && a[7:2] < 16) m_match[a[5:2]] = d;
      else if (a[11:8] == 4'h2 && a[1:0] == 2'b00 && a[7:2] < 16) m_shadow[a[5:2]] = d;
      else if (a[11:8] == 4'h3 && a[1:0] == 2'b00 && a[7:3] < 16) begin
         if (a[2]) begin m_sel[a[6:3]] = d[3:0]; m_mode[a[6:3]] = d[13:12]; end
         else m_arm[a[6:3]] = d[0];
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_unified = 0; m_norefr = 0; m_halt = 1; m_dir = 0; m_div = 0; m_pre = 0;
         m_limit = 0; m_evt = 0; m_cnt = 0;
         for (int i = 0; i < 16; i++) begin
            m_match[i] = 0; m_shadow[i] = 0; m_sel[i] = 0; m_mode[i] = 0; m_arm[i] = 0;
         end
      end else begin
         for (int e = 0; e < 16; e++)
            m_fire[e] = (m_mode[e] == 2'd1) && m_arm[e] && (m_cnt == m_match[m_sel[e]]);
         m_tick = !m_halt && (m_pre >= m_div);
         if (m_halt) begin
            m_pre = 0; m_evt = 0;
         end else if (m_tick) begin
            m_pre = 0;
            m_evt = m_fire;
            m_hit = |(m_fire & m_limit);
            m_cnt = m_hit ? 32'd0 : m_cnt + 1;
            if (m_hit && !m_norefr)
               for (int n = 0; n < 16; n++) m_match[n] = m_shadow[n];
         end else begin
            m_pre = m_pre + 1;
         end
         if (bus_wr) model_write(bus_addr, bus_wdata);
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n && chk_en && !done) begin
         chk(tag, {16'h0, evt_o}, {16'h0, m_evt});
         if (!bus_wr && bus_addr == 12'h040) chk(tag, bus_rdata, m_cnt);
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 12'h040; bus_wdata = '0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
      bus_addr = 12'h040;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      finish_up();
   end

   // ---------------- stimulus ----------------
   initial begin
      int pulses;
      logic [31:0] mx, held;
      void'($urandom(32'h5eed_0042));
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      rd_chk("R1", 12'h004, 32'h0000_0004);
      rd_chk("R1", 12'h000, 32'h0);
      rd_chk("R1", 12'h008, 32'h0);
      rd_chk("R1", 12'h10c, 32'h0);
      rd_chk("R1", 12'h040, 32'h0);
      chk("R1", {16'h0, evt_o}, 32'h0);
      chk_en = 1'b1;

      // R2: read-back of implemented fields
      tag = "R2";
      wr(12'h000, 32'hffff_ffff); rd_chk("R2", 12'h000, 32'h0000_0081);
      wr(12'h004, 32'hffff_ffff); rd_chk("R2", 12'h004, 32'h0000_1ff4);
      wr(12'h004, 32'h0000_0004);
      wr(12'h000, 32'h0);
      wr(12'h008, 32'hffff_ffff); rd_chk("R2", 12'h008, 32'h0000_ffff);
      wr(12'h008, 32'h0);
      wr(12'h32c, 32'hffff_ffff); rd_chk("R2", 12'h32c, 32'h0000_300f);
      wr(12'h328, 32'hffff_ffff); rd_chk("R2", 12'h328, 32'h0000_0001);
      wr(12'h32c, 32'h0); wr(12'h328, 32'h0);
      wr(12'h11c, 32'hdead_beef); rd_chk("R2", 12'h11c, 32'hdead_beef);
      wr(12'h208, 32'h1234_5678); rd_chk("R2", 12'h208, 32'h1234_5678);

      // R9: the count is read-only
      tag = "R9";
      wr(12'h040, 32'h55);
      rd_chk("R9", 12'h040, 32'h0);

      // R6: period of 5 counts from a comparison value of 4
      tag = "R6";
      wr(12'h100, 32'd4); wr(12'h200, 32'd4);
      wr(12'h304, 32'h0000_1000); wr(12'h300, 32'h1);
      wr(12'h008, 32'h1);
      wr(12'h004, 32'h0);
      pulses = 0; mx = 0;
      repeat (25) begin
         @(negedge clk);
         if (evt_o[0]) pulses++;
         if (bus_rdata > mx) mx = bus_rdata;
      end
      chk("R6", pulses, 32'd5);
      chk("R6", mx, 32'd4);

      // R4: a second event inside the period
      tag = "R4";
      wr(12'h104, 32'd2); wr(12'h204, 32'd2);
      wr(12'h30c, 32'h0000_1001); wr(12'h308, 32'h1);
      pulses = 0;
      repeat (20) begin
         @(negedge clk);
         if (evt_o[1]) pulses++;
      end
      chk("R4", pulses, 32'd4);

      // R5: wrong trigger mode, or not armed
      tag = "R5";
      wr(12'h314, 32'h0000_2001); wr(12'h310, 32'h1);
      wr(12'h31c, 32'h0000_1001); wr(12'h318, 32'h0);
      pulses = 0;
      repeat (20) begin
         @(negedge clk);
         if (evt_o[3:2] != 2'b00) pulses++;
      end
      chk("R5", pulses, 32'd0);

      // R3: prescale divider 3
      tag = "R3";
      wr(12'h004, 32'h0000_0060);
      idle(40);

      // R11: direction bit leaves the count going up
      tag = "R11";
      wr(12'h004, 32'h0000_0030);
      idle(30);

      // R10: halt freezes everything
      tag = "R10";
      wr(12'h004, 32'h0000_0004);
      @(negedge clk); held = bus_rdata;
      idle(10);
      chk("R10", bus_rdata, held);
      chk("R10", {16'h0, evt_o}, 32'h0);

      // R7: boundary refresh lengthens the period to 10
      tag = "R7";
      wr(12'h004, 32'h0);
      wr(12'h200, 32'd9);
      idle(15);
      mx = 0;
      repeat (30) begin
         @(negedge clk);
         if (bus_rdata > mx) mx = bus_rdata;
      end
      chk("R7", mx, 32'd9);
      wr(12'h000, 32'h0000_0080);
      wr(12'h200, 32'd2);
      idle(12);
      mx = 0;
      repeat (30) begin
         @(negedge clk);
         if (bus_rdata > mx) mx = bus_rdata;
      end
      chk("R7", mx, 32'd9);
      wr(12'h000, 32'h0);

      // R8: bus write on the very refresh clock
      tag = "R8";
      wr(12'h200, 32'd4);
      wr(12'h100, 32'd4);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (bus_rdata == 32'd4) break;
      end
      bus_wr = 1'b1; bus_addr = 12'h100; bus_wdata = 32'd7;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 12'h040; bus_wdata = '0;
      rd_chk("R8", 12'h100, 32'd7);

      // random phases: R4 R6 R7 R8 under mixed settings
      for (int r = 0; r < 8; r++) begin
         tag = "R4";
         wr(12'h004, 32'h0000_0004);
         for (int e = 1; e < 4; e++) begin
            wr(12'h304 + 12'(8 * e), {18'h0, 2'($urandom % 3), 8'h0, 4'($urandom % 4)});
            wr(12'h300 + 12'(8 * e), 32'($urandom % 2));
         end
         wr(12'h304, 32'h0000_1000); wr(12'h300, 32'h1);
         for (int n = 0; n < 4; n++) begin
            wr(12'h100 + 12'(4 * n), 32'($urandom % 12));
            wr(12'h200 + 12'(4 * n), 32'($urandom % 12));
         end
         wr(12'h008, 32'($urandom % 16) | 32'h1);
         wr(12'h000, (r == 5) ? 32'h80 : 32'h0);
         wr(12'h004, 32'($urandom % 3) << 5);
         tag = "R8";
         for (int k = 0; k < 40; k++) begin
            if ($urandom % 4 == 0)
               wr(((($urandom % 2) != 0) ? 12'h100 : 12'h200) + 12'(4 * ($urandom % 4)),
                  32'($urandom % 12));
            else
               idle(1);
         end
      end

      idle(2);
      finish_up();
   end
endmodule